// File: doc/BRIEF.md
# Fault Escalation and Pending Arbiter

This block sits beside a processor core's exception logic and decides, each cycle, what a freshly detected fault turns into. Fault events arrive as one-cycle pulses: a memory-protection fault, a precise bus fault, a usage fault, a vector-table read error, a bus fault during the stack push on entry to the bus-fault handler, and an imprecise (buffered-write) bus fault. Three of these classes are configurable. Each has an enable bit and an 8-bit priority, where a lower value means more urgent.

The arbiter compares each fault with the current execution priority. A fault whose class is disabled, or whose priority cannot preempt the running handler, is redirected to the fixed-priority HardFault, and a forced-escalation strobe marks the redirect. An imprecise bus fault is never taken at once. It is held as a pending flag, either for the bus-fault handler or, when that handler is disabled, for HardFault. It is released once the running context can be preempted. A synchronous fault raised while the NMI or HardFault handler is running cannot be serviced, so it is reported on a lockup flag.

The decision is registered. The exception number, the forced strobe and the lockup flag appear one cycle after the fault input, for a single cycle.

Top module: `fault_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `exc_valid`, `exc_num`, `exc_forced`, `lockup`, `pend_bus` and `pend_hard` are all 0.
- R2: A synchronous fault whose class is enabled and can preempt is reported as its own exception, one cycle after the input pulse, with `exc_forced`=0. A fault can preempt when `in_handler`=0, or when its priority value is strictly below `cur_pri`. Exception numbers: 3 HardFault, 4 memory-protection, 5 bus, 6 usage.
- R3: A synchronous fault whose class enable is 0 is reported as `exc_num`=3 with `exc_forced`=1.
- R4: With `in_handler`=1, a synchronous fault whose priority value is equal to or above `cur_pri` is reported as `exc_num`=3 with `exc_forced`=1.
- R5: When several enabled, preemptable synchronous faults arrive in the same cycle, the lowest priority value wins. On equal values, the lower exception number wins.
- R6: A vector-table read error is reported as `exc_num`=3 with `exc_forced`=0, whatever the enables are.
- R7: A synchronous fault (memory, precise bus, usage or vector error) arriving while `nmi_active` or `hf_active` is 1 gives `lockup`=1 and `exc_valid`=0 in the next cycle.
- R8: An imprecise bus fault produces no exception in the next cycle. If `en_bus`=1 it sets `pend_bus`; otherwise it sets `pend_hard`. It never raises `lockup`.
- R9: A pending bus fault is taken as `exc_num`=5 with `exc_forced`=0, and `pend_bus` clears in the same cycle. This happens in a cycle with no synchronous fault, with neither `nmi_active` nor `hf_active` set, with `en_bus`=1, and with the bus priority able to preempt. Until then it stays pending.
- R10: A pending HardFault is taken as `exc_num`=3 with `exc_forced`=1, and `pend_hard` clears, in a cycle with no synchronous fault and neither `nmi_active` nor `hf_active` set.
- R11: A bus fault on the stack push into the bus-fault handler is reported as `exc_num`=5 with `exc_forced`=0, even when `en_bus`=0 or the priority could not preempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_mem | input | 1 | Memory-protection fault pulse |
| flt_bus_prec | input | 1 | Precise bus fault pulse |
| flt_bus_imprec | input | 1 | Imprecise bus fault pulse |
| flt_usage | input | 1 | Usage fault pulse |
| flt_vector | input | 1 | Vector-table read error pulse |
| flt_stack_bus | input | 1 | Bus fault on stack push into the bus-fault handler |
| en_mem | input | 1 | Memory-protection class enable |
| en_bus | input | 1 | Bus class enable |
| en_usage | input | 1 | Usage class enable |
| pri_mem | input | PRI_W | Memory-protection priority (lower is more urgent) |
| pri_bus | input | PRI_W | Bus priority |
| pri_usage | input | PRI_W | Usage priority |
| cur_pri | input | PRI_W | Current execution priority |
| in_handler | input | 1 | 1 when a handler is running and `cur_pri` applies |
| nmi_active | input | 1 | NMI handler running |
| hf_active | input | 1 | HardFault handler running |
| exc_valid | output | 1 | An exception is selected this cycle |
| exc_num | output | 4 | Selected exception number (0 when none) |
| exc_forced | output | 1 | Selected exception is an escalated HardFault |
| lockup | output | 1 | Unserviceable synchronous fault |
| pend_bus | output | 1 | Imprecise bus fault waiting for the bus handler |
| pend_hard | output | 1 | Imprecise bus fault waiting for HardFault |

## Verification
The bench sweeps every configurable class over enable, priority, current priority and handler state, so the equal-priority boundary is always covered. A design that used a non-strict comparison would take a fault it should escalate there. Pairs of simultaneous faults are swept over all priority combinations, which exposes a tie-break that favours the higher exception number. Pending sequences hold the deferral through a blocked cycle. They would catch a design that takes an imprecise fault at once, drops the pending flag, or pends the wrong handler. Faults under an active HardFault check that lockup replaces selection while an imprecise fault still only pends. The stack-push case checks that the bus handler is reported without escalation.

// File: rtl/fault_arb_pkg.sv
package fault_arb_pkg;
  localparam int NUM_W = 4;
  localparam int NCLS  = 3;
  localparam logic [NUM_W-1:0] EXC_NONE  = 4'd0;
  localparam logic [NUM_W-1:0] EXC_HARD  = 4'd3;
  localparam logic [NUM_W-1:0] EXC_MEM   = 4'd4;
  localparam logic [NUM_W-1:0] EXC_BUS   = 4'd5;
  localparam logic [NUM_W-1:0] EXC_USAGE = 4'd6;
  localparam logic [NUM_W-1:0] EXC_BASE  = EXC_MEM;
endpackage

// File: rtl/fault_class_eval.sv
module fault_class_eval #(
  parameter int PRI_W = 8
) (
  input  logic             hit,
  input  logic             en,
  input  logic [PRI_W-1:0] pri,
  input  logic [PRI_W-1:0] cur_pri,
  input  logic             in_handler,
  output logic             take,
  output logic             escalate
);
  logic can_preempt;

  always_comb begin
    can_preempt = !in_handler || (pri < cur_pri);
    take        = hit && en && can_preempt;
    escalate    = hit && !(en && can_preempt);
  end
endmodule

// File: rtl/fault_pick.sv
module fault_pick #(
  parameter int PRI_W = 8,
  parameter int N     = 3
) (
  input  logic [N-1:0]       req,
  input  logic [N*PRI_W-1:0] pri_flat,
  output logic               any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);
  logic [PRI_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!any || (pri_flat[i*PRI_W +: PRI_W] < best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = pri_flat[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/fault_pend.sv
module fault_pend (
  input  logic clk,
  input  logic rst,
  input  logic imprecise,
  input  logic en_bus,
  input  logic take_bus,
  input  logic take_hard,
  output logic pend_bus,
  output logic pend_hard
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_bus  <= 1'b0;
      pend_hard <= 1'b0;
    end else begin
      if (imprecise && en_bus)       pend_bus <= 1'b1;
      else if (take_bus)             pend_bus <= 1'b0;
      if (imprecise && !en_bus)      pend_hard <= 1'b1;
      else if (take_hard)            pend_hard <= 1'b0;
    end
  end

  AST_BUS_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_bus) |-> $past(imprecise && en_bus)); // R8
  AST_HARD_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_hard) |-> $past(imprecise && !en_bus)); // R8
endmodule

// File: rtl/fault_arbiter.sv
module fault_arbiter
  import fault_arb_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flt_mem,
  input  logic             flt_bus_prec,
  input  logic             flt_bus_imprec,
  input  logic             flt_usage,
  input  logic             flt_vector,
  input  logic             flt_stack_bus,
  input  logic             en_mem,
  input  logic             en_bus,
  input  logic             en_usage,
  input  logic [PRI_W-1:0] pri_mem,
  input  logic [PRI_W-1:0] pri_bus,
  input  logic [PRI_W-1:0] pri_usage,
  input  logic [PRI_W-1:0] cur_pri,
  input  logic             in_handler,
  input  logic             nmi_active,
  input  logic             hf_active,
  output logic             exc_valid,
  output logic [3:0]       exc_num,
  output logic             exc_forced,
  output logic             lockup,
  output logic             pend_bus,
  output logic             pend_hard
);
  localparam int IW = $clog2(NCLS);

  logic [NCLS-1:0]       hit_v, en_v, take_v, esc_v;
  logic [NCLS*PRI_W-1:0] pri_flat;
  logic                  pick_any;
  logic [IW-1:0]         pick_idx;

  assign hit_v    = {flt_usage, flt_bus_prec, flt_mem};
  assign en_v     = {en_usage, en_bus, en_mem};
  assign pri_flat = {pri_usage, pri_bus, pri_mem};

  generate
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
      fault_class_eval #(.PRI_W(PRI_W)) u_eval (
        .hit        (hit_v[g]),
        .en         (en_v[g]),
        .pri        (pri_flat[g*PRI_W +: PRI_W]),
        .cur_pri    (cur_pri),
        .in_handler (in_handler),
        .take       (take_v[g]),
        .escalate   (esc_v[g])
      );
    end
  endgenerate

  fault_pick #(.PRI_W(PRI_W), .N(NCLS)) u_pick (
    .req      (take_v),
    .pri_flat (pri_flat),
    .any      (pick_any),
    .idx      (pick_idx)
  );

  logic             sync_any, blocked, bus_ok;
  logic             valid_d, forced_d, lock_d, take_bus_d, take_hard_d;
  logic [NUM_W-1:0] num_d;

  always_comb begin
    sync_any    = (|hit_v) || flt_vector;
    blocked     = nmi_active || hf_active;
    bus_ok      = en_bus && (!in_handler || (pri_bus < cur_pri));
    valid_d     = 1'b0;
    forced_d    = 1'b0;
    lock_d      = 1'b0;
    take_bus_d  = 1'b0;
    take_hard_d = 1'b0;
    num_d       = EXC_NONE;
    if (blocked && sync_any) begin
      lock_d = 1'b1;
    end else if (flt_vector || (|esc_v)) begin
      valid_d  = 1'b1;
      num_d    = EXC_HARD;
      forced_d = |esc_v;
    end else if (flt_stack_bus) begin
      valid_d = 1'b1;
      num_d   = EXC_BUS;
    end else if (pick_any) begin
      valid_d = 1'b1;
      num_d   = EXC_BASE + NUM_W'(pick_idx);
    end else if (!blocked && pend_hard) begin
      valid_d     = 1'b1;
      num_d       = EXC_HARD;
      forced_d    = 1'b1;
      take_hard_d = 1'b1;
    end else if (!blocked && pend_bus && bus_ok) begin
      valid_d    = 1'b1;
      num_d      = EXC_BUS;
      take_bus_d = 1'b1;
    end
  end

  fault_pend u_pend (
    .clk       (clk),
    .rst       (rst),
    .imprecise (flt_bus_imprec),
    .en_bus    (en_bus),
    .take_bus  (take_bus_d),
    .take_hard (take_hard_d),
    .pend_bus  (pend_bus),
    .pend_hard (pend_hard)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid  <= 1'b0;
      exc_num    <= EXC_NONE;
      exc_forced <= 1'b0;
      lockup     <= 1'b0;
    end else begin
      exc_valid  <= valid_d;
      exc_num    <= num_d;
      exc_forced <= forced_d;
      lockup     <= lock_d;
    end
  end

  AST_FORCED_IS_HARD: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_forced) |-> (exc_num == EXC_HARD)); // R3
  AST_LOCK_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    lockup |-> !exc_valid); // R7
  AST_LOCK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    lockup |-> $past(nmi_active || hf_active)); // R7
  AST_BUS_PEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pend_bus)) |-> (exc_valid && exc_num == EXC_BUS && !exc_forced)); // R9
  AST_HARD_PEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pend_hard)) |-> (exc_valid && exc_num == EXC_HARD && exc_forced)); // R10
  AST_NUM_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> (exc_num == EXC_NONE && !exc_forced)); // R2
endmodule

// File: tb/sim_fault_arbiter.sv
module sim_fault_arbiter;
  logic clk = 1'b0;
  logic rst;
  logic f_mem, f_bp, f_bi, f_us, f_vec, f_stk;
  logic e_mem, e_bus, e_us;
  logic [7:0] p_mem, p_bus, p_us, cur;
  logic inh, nmi, hfa;
  logic exc_valid, exc_forced, lockup, pend_bus, pend_hard;
  logic [3:0] exc_num;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fault_arbiter #(.PRI_W(8)) u0 (
    .clk(clk), .rst(rst),
    .flt_mem(f_mem), .flt_bus_prec(f_bp), .flt_bus_imprec(f_bi),
    .flt_usage(f_us), .flt_vector(f_vec), .flt_stack_bus(f_stk),
    .en_mem(e_mem), .en_bus(e_bus), .en_usage(e_us),
    .pri_mem(p_mem), .pri_bus(p_bus), .pri_usage(p_us),
    .cur_pri(cur), .in_handler(inh), .nmi_active(nmi), .hf_active(hfa),
    .exc_valid(exc_valid), .exc_num(exc_num), .exc_forced(exc_forced),
    .lockup(lockup), .pend_bus(pend_bus), .pend_hard(pend_hard)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_faults();
    f_mem = 0; f_bp = 0; f_bi = 0; f_us = 0; f_vec = 0; f_stk = 0;
  endtask

  task automatic set_class(int c);
    if (c == 0) f_mem = 1;
    else if (c == 1) f_bp = 1;
    else f_us = 1;
  endtask

  task automatic set_cfg(int c, bit en, int p);
    if (c == 0) begin e_mem = en; p_mem = 8'(p); end
    else if (c == 1) begin e_bus = en; p_bus = 8'(p); end
    else begin e_us = en; p_us = 8'(p); end
  endtask

  // drive at negedge, decision registers at posedge, sample at next negedge
  task automatic step();
    @(negedge clk);
    clear_faults();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; clear_faults();
    e_mem = 0; e_bus = 0; e_us = 0; p_mem = 0; p_bus = 0; p_us = 0;
    cur = 0; inh = 0; nmi = 0; hfa = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", exc_valid, 0);
    chk("R1 pend in reset", {pend_bus, pend_hard}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 valid after", exc_valid, 0);
    chk("R1 num after", exc_num, 0);
    chk("R1 lockup after", lockup, 0);

    // single fault sweep: R2 R3 R4
    for (int c = 0; c < 3; c++)
      for (int en = 0; en < 2; en++)
        for (int p = 0; p < 4; p++)
          for (int cp = 0; cp < 4; cp++)
            for (int h = 0; h < 2; h++) begin
              int en_num, en_f;
              e_mem = 0; e_bus = 0; e_us = 0;
              set_cfg(c, en[0], p); cur = 8'(cp); inh = h[0];
              set_class(c);
              if (en == 0) begin en_num = 3; en_f = 1; end
              else if (h == 1 && p >= cp) begin en_num = 3; en_f = 1; end
              else begin en_num = 4 + c; en_f = 0; end
              step();
              chk(en == 0 ? "R3 num" : (en_f == 1 ? "R4 num" : "R2 num"), exc_num, en_num);
              chk("R2 forced", exc_forced, en_f);
              chk("R2 valid", exc_valid, 1);
            end
    @(negedge clk);
    chk("R2 idle after pulse", exc_valid, 0);

    // pairwise simultaneous: R5
    inh = 0; e_mem = 1; e_bus = 1; e_us = 1;
    for (int a = 0; a < 3; a++)
      for (int b = a + 1; b < 3; b++)
        for (int pa = 0; pa < 4; pa++)
          for (int pb = 0; pb < 4; pb++) begin
            set_cfg(a, 1, pa); set_cfg(b, 1, pb);
            set_class(a); set_class(b);
            step();
            chk("R5 winner", exc_num, (pb < pa) ? 4 + b : 4 + a);
          end

    // vector error: R6
    e_mem = 0; e_bus = 0; e_us = 0; inh = 1; cur = 0;
    f_vec = 1; step();
    chk("R6 num", exc_num, 3);
    chk("R6 forced", exc_forced, 0);

    // lockup: R7
    hfa = 1; e_mem = 1; p_mem = 0; inh = 0;
    f_mem = 1; step();
    chk("R7 lockup hf", lockup, 1);
    chk("R7 no select", exc_valid, 0);
    hfa = 0; nmi = 1; f_vec = 1; step();
    chk("R7 lockup nmi", lockup, 1);
    nmi = 0;

    // imprecise pends for bus: R8 R9
    e_bus = 1; p_bus = 8'd5; inh = 1; cur = 8'd2;
    f_bi = 1; step();
    chk("R8 no exc", exc_valid, 0);
    chk("R8 pend bus", pend_bus, 1);
    chk("R8 no lockup", lockup, 0);
    step();
    chk("R9 held", pend_bus, 1);
    chk("R9 held no exc", exc_valid, 0);
    inh = 0; step();
    chk("R9 taken num", exc_num, 5);
    chk("R9 taken forced", exc_forced, 0);
    chk("R9 cleared", pend_bus, 0);

    // imprecise with bus disabled pends HardFault: R8 R10
    e_bus = 0; hfa = 1;
    f_bi = 1; step();
    chk("R8 pend hard", pend_hard, 1);
    chk("R8 no lockup under hf", lockup, 0);
    step();
    chk("R10 held", pend_hard, 1);
    hfa = 0; step();
    chk("R10 num", exc_num, 3);
    chk("R10 forced", exc_forced, 1);
    chk("R10 cleared", pend_hard, 0);

    // stack push fault on bus entry: R11
    e_bus = 0; inh = 1; cur = 0;
    f_stk = 1; step();
    chk("R11 num", exc_num, 5);
    chk("R11 forced", exc_forced, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule